// File: doc/BRIEF.md
# UART FIFO Interrupt Generator

This block produces the active-low interrupt request of one UART channel. It watches the fill levels of the receive and transmit FIFOs, compares them against programmed trigger levels, and turns those comparisons into interrupt sources. It also takes a receive-data timeout pulse and three one-cycle host strobes: a transmit write, a receive read and a status read. The pending source with the highest priority is presented as a 3-bit status code. The request pin stays low for as long as any enabled source is pending.

In FIFO mode the receive source follows the receive level against its trigger, or a latched timeout. The transmit source fires when the transmit level drops below its trigger. In non-FIFO mode the receive source follows "any data present". The transmit source fires when the holding register becomes empty. A transmit source has two ways to clear. One is a status read. The other is a FIFO refill up to the trigger in FIFO mode, or a holding-register write in non-FIFO mode. Every control and status pin is a plain level or a single-cycle strobe. No stream interface is present. Pending flags are registered, so the outputs follow an input change after one clock edge.

Top module: `uart_irq_gen`

## Requirements
- R1: After reset `irq_n` is 1 and `isr_code` is 3'b001 (none). A transmit FIFO that is already below its trigger at reset raises no transmit source until the level crosses the threshold afresh.
- R2: In FIFO mode a receive-level source (code 3'b100) is pending while `rx_level >= rx_trig`, where a trigger of 0 acts as 1. The source is withdrawn once the level falls below the trigger.
- R3: In FIFO mode an `rx_timeout` pulse latches a timeout source (code 3'b110). The latch holds until the next `host_rx_rd` strobe. A timeout pulse in the same cycle as a read wins.
- R4: In FIFO mode the transmit source (code 3'b010) is raised when `tx_level < tx_trig` becomes true after having been false.
- R5: A `host_isr_rd` strobe clears the transmit source. That source is raised again only by a new crossing, meaning the level reaches the trigger and then drops below it again.
- R6: In FIFO mode the transmit source clears when `tx_level` is refilled to `tx_trig` or above.
- R7: In non-FIFO mode a rising `thr_empty` raises the transmit source. A `host_tx_wr` strobe or a `host_isr_rd` strobe clears it.
- R8: In non-FIFO mode the receive-level source is pending while `rx_level` is nonzero, whatever the trigger. `rx_timeout` has no effect in this mode.
- R9: A `host_isr_rd` strobe does not clear a receive-level or timeout source.
- R10: The status code gives priority to the receive level, then the timeout, then the transmit source. `irq_n` is 0 exactly while the code is not 3'b001.
- R11: `ier_rx_en` masks both receive sources, and `ier_tx_en` masks the transmit source, in both `irq_n` and `isr_code`. A transmit source that is pending while masked is kept, and it appears as soon as the mask is lifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode | input | 1 | 1 = FIFO mode, 0 = non-FIFO mode |
| ier_rx_en | input | 1 | Receive interrupt enable |
| ier_tx_en | input | 1 | Transmit interrupt enable |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_trig | input | LVL_W | Receive trigger level |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| tx_trig | input | LVL_W | Transmit trigger level |
| rx_timeout | input | 1 | Receive-data timeout pulse |
| thr_empty | input | 1 | Holding register empty (non-FIFO mode) |
| host_tx_wr | input | 1 | Host write strobe to the transmit holding register or FIFO |
| host_rx_rd | input | 1 | Host read strobe from the receive FIFO |
| host_isr_rd | input | 1 | Host read strobe of the interrupt status register |
| irq_n | output | 1 | Interrupt request, active low |
| isr_code | output | 3 | Highest-priority pending source |

## Verification
The bench first stresses the re-arming rule. It reads status and then moves the transmit level further below the trigger. A design that re-arms on the level rather than on the crossing would raise the interrupt again at that point. It checks that a status read taken while both a receive and a transmit source are pending leaves the receive source in place. A design that clears every source on that read would release the pin too early. It checks the priority order among level, timeout and transmit codes, and the rule that a trigger of zero acts as one. In non-FIFO mode it checks that a holding-register write clears the transmit source and that a timeout pulse is ignored. It also checks that a masked transmit source survives and then appears once it is enabled.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [2:0] {
    IRQ_NONE   = 3'b001,
    IRQ_TX     = 3'b010,
    IRQ_RX_LVL = 3'b100,
    IRQ_RX_TMO = 3'b110
  } irq_code_e;
endpackage

// File: rtl/uart_irq_rx_src.sv
module uart_irq_rx_src #(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic             rx_timeout,
  input  logic             host_rx_rd,
  output logic             lvl_pend,
  output logic             tmo_pend
);
  localparam logic [LVL_W-1:0] ONE = LVL_W'(1);

  logic [LVL_W-1:0] eff_trig;
  logic             lvl_hit;

  always_comb begin
    if (!fifo_mode)          eff_trig = ONE;
    else if (rx_trig == '0)  eff_trig = ONE;
    else                     eff_trig = rx_trig;
    lvl_hit = (rx_level >= eff_trig);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_pend <= 1'b0;
      tmo_pend <= 1'b0;
    end else begin
      lvl_pend <= lvl_hit;
      if (!fifo_mode)      tmo_pend <= 1'b0;
      else if (rx_timeout) tmo_pend <= 1'b1;
      else if (host_rx_rd) tmo_pend <= 1'b0;
    end
  end

  // R3: timeout latches in FIFO mode
  a_r3_tmo_sets: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_mode && rx_timeout |=> tmo_pend);
  // R3: a read without a new timeout clears the latch
  a_r3_read_clears_tmo: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_mode && host_rx_rd && !rx_timeout |=> !tmo_pend);
  // R8: no timeout source outside FIFO mode
  a_r8_no_tmo_nonfifo: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |=> !tmo_pend);
endmodule

// File: rtl/uart_irq_tx_src.sv
module uart_irq_tx_src #(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] tx_trig,
  input  logic             thr_empty,
  input  logic             host_tx_wr,
  input  logic             host_isr_rd,
  output logic             tx_pend
);
  logic below;
  logic arm;
  logic arm_q;
  logic rise;
  logic clr;

  always_comb begin
    below = (tx_level < tx_trig);
    arm   = fifo_mode ? below : thr_empty;
    rise  = arm && !arm_q;
    clr   = host_isr_rd || (fifo_mode ? !below : host_tx_wr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q   <= 1'b1;
      tx_pend <= 1'b0;
    end else begin
      arm_q <= arm;
      if (rise)     tx_pend <= 1'b1;
      else if (clr) tx_pend <= 1'b0;
    end
  end

  // R5: status read clears the transmit source unless a new crossing arrives
  a_r5_isr_clears_tx: assert property (@(posedge clk) disable iff (!rst_n)
    host_isr_rd && !rise |=> !tx_pend);
  // R7: holding-register write clears in non-FIFO mode
  a_r7_wr_clears_tx: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode && host_tx_wr && !rise |=> !tx_pend);
  // R6: refill to trigger clears in FIFO mode
  a_r6_refill_clears_tx: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_mode && !below && !rise |=> !tx_pend);
endmodule

// File: rtl/uart_irq_encode.sv
module uart_irq_encode
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ier_rx_en,
  input  logic       ier_tx_en,
  input  logic       lvl_pend,
  input  logic       tmo_pend,
  input  logic       tx_pend,
  output logic       irq_n,
  output logic [2:0] isr_code
);
  irq_code_e code;

  always_comb begin
    if (ier_rx_en && lvl_pend)      code = IRQ_RX_LVL;
    else if (ier_rx_en && tmo_pend) code = IRQ_RX_TMO;
    else if (ier_tx_en && tx_pend)  code = IRQ_TX;
    else                            code = IRQ_NONE;
    isr_code = code;
    irq_n    = (code == IRQ_NONE);
  end

  // R10: transmit code never hides an enabled receive source
  a_r10_rx_first: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_code == IRQ_TX) |-> !(ier_rx_en && (lvl_pend || tmo_pend)));
  // R11: a masked source never drives the pin
  a_r11_mask_tx: assert property (@(posedge clk) disable iff (!rst_n)
    !ier_rx_en && !ier_tx_en |-> irq_n);
endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen #(
  parameter int FIFO_DEPTH = 64,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode,
  input  logic             ier_rx_en,
  input  logic             ier_tx_en,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] tx_trig,
  input  logic             rx_timeout,
  input  logic             thr_empty,
  input  logic             host_tx_wr,
  input  logic             host_rx_rd,
  input  logic             host_isr_rd,
  output logic             irq_n,
  output logic [2:0]       isr_code
);
  logic lvl_pend;
  logic tmo_pend;
  logic tx_pend;

  uart_irq_rx_src #(.LVL_W(LVL_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
    .rx_level(rx_level), .rx_trig(rx_trig), .rx_timeout(rx_timeout),
    .host_rx_rd(host_rx_rd), .lvl_pend(lvl_pend), .tmo_pend(tmo_pend)
  );

  uart_irq_tx_src #(.LVL_W(LVL_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
    .tx_level(tx_level), .tx_trig(tx_trig), .thr_empty(thr_empty),
    .host_tx_wr(host_tx_wr), .host_isr_rd(host_isr_rd), .tx_pend(tx_pend)
  );

  uart_irq_encode u_enc (
    .clk(clk), .rst_n(rst_n), .ier_rx_en(ier_rx_en), .ier_tx_en(ier_tx_en),
    .lvl_pend(lvl_pend), .tmo_pend(tmo_pend), .tx_pend(tx_pend),
    .irq_n(irq_n), .isr_code(isr_code)
  );

  // R9: a status read leaves a receive-level source in place
  a_r9_isr_keeps_rx: assert property (@(posedge clk) disable iff (!rst_n)
    host_isr_rd && lvl_pend && ier_rx_en && fifo_mode &&
    (rx_level >= rx_trig) && (rx_trig != '0) |=> !irq_n);
endmodule

// File: tb/uart_irq_gen_test.sv
module uart_irq_gen_test;
  localparam int LW = 7;
  localparam logic [2:0] C_NONE = 3'b001, C_TX = 3'b010,
                         C_RXL = 3'b100, C_TMO = 3'b110;

  logic clk = 0, rst_n = 0;
  logic fifo_mode, ier_rx_en, ier_tx_en;
  logic [LW-1:0] rx_level, rx_trig, tx_level, tx_trig;
  logic rx_timeout, thr_empty, host_tx_wr, host_rx_rd, host_isr_rd;
  logic irq_n;
  logic [2:0] isr_code;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_irq_gen #(.FIFO_DEPTH(64)) uut (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
    .ier_rx_en(ier_rx_en), .ier_tx_en(ier_tx_en),
    .rx_level(rx_level), .rx_trig(rx_trig), .tx_level(tx_level), .tx_trig(tx_trig),
    .rx_timeout(rx_timeout), .thr_empty(thr_empty), .host_tx_wr(host_tx_wr),
    .host_rx_rd(host_rx_rd), .host_isr_rd(host_isr_rd),
    .irq_n(irq_n), .isr_code(isr_code)
  );

  task automatic chk(input string req, input logic [2:0] exp_code);
    logic exp_irq;
    exp_irq = (exp_code == C_NONE);
    checks++;
    if (irq_n !== exp_irq || isr_code !== exp_code) begin
      failures++;
      $display("FAIL %s: irq_n=%b code=%b expected irq_n=%b code=%b",
               req, irq_n, isr_code, exp_irq, exp_code);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic test_reset();
    chk("R1", C_NONE);
    tick(); chk("R1", C_NONE);
  endtask

  task automatic test_rx_level();
    rx_level = 4; tick(); chk("R2", C_RXL);
    rx_level = 3; tick(); chk("R2", C_NONE);
    rx_trig = 0; rx_level = 1; tick(); chk("R2", C_RXL);
    rx_level = 0; tick(); chk("R2", C_NONE);
    rx_trig = 4;
  endtask

  task automatic test_timeout();
    rx_timeout = 1; tick(); rx_timeout = 0; chk("R3", C_TMO);
    tick(); chk("R3", C_TMO);
    host_rx_rd = 1; rx_timeout = 1; tick(); host_rx_rd = 0; rx_timeout = 0;
    chk("R3", C_TMO);
    host_rx_rd = 1; tick(); host_rx_rd = 0; chk("R3", C_NONE);
  endtask

  task automatic test_tx_fifo();
    tx_level = 8; tick(); chk("R4", C_NONE);
    tx_level = 7; tick(); chk("R4", C_TX);
    host_isr_rd = 1; tick(); host_isr_rd = 0; chk("R5", C_NONE);
    tx_level = 5; tick(); chk("R5", C_NONE);
    tx_level = 8; tick(); chk("R5", C_NONE);
    tx_level = 2; tick(); chk("R5", C_TX);
    tx_level = 8; tick(); chk("R6", C_NONE);
  endtask

  task automatic test_priority();
    rx_level = 4; tx_level = 2; tick(); chk("R10", C_RXL);
    host_isr_rd = 1; tick(); host_isr_rd = 0; chk("R9", C_RXL);
    rx_level = 0; tick(); chk("R9", C_NONE);
    tx_level = 8; tick(); tx_level = 2; tick(); chk("R10", C_TX);
    rx_timeout = 1; tick(); rx_timeout = 0; chk("R10", C_TMO);
    host_isr_rd = 1; tick(); host_isr_rd = 0; chk("R9", C_TMO);
    host_rx_rd = 1; tick(); host_rx_rd = 0; chk("R10", C_NONE);
    tx_level = 8; tick(); tx_level = 2; tick(); chk("R10", C_TX);
    rx_level = 4; rx_timeout = 1; tick(); rx_timeout = 0; chk("R10", C_RXL);
    rx_level = 0; tick(); chk("R10", C_TMO);
    host_rx_rd = 1; tick(); host_rx_rd = 0; chk("R10", C_TX);
    host_isr_rd = 1; tick(); host_isr_rd = 0; chk("R5", C_NONE);
  endtask

  task automatic test_enables();
    ier_tx_en = 0; tx_level = 8; tick(); tx_level = 2; tick(); chk("R11", C_NONE);
    ier_tx_en = 1; tick(); chk("R11", C_TX);
    host_isr_rd = 1; tick(); host_isr_rd = 0;
    ier_rx_en = 0; rx_level = 4; tick(); chk("R11", C_NONE);
    ier_rx_en = 1; tick(); chk("R11", C_RXL);
    rx_level = 0; tx_level = 8; tick(); chk("R11", C_NONE);
  endtask

  task automatic test_nonfifo();
    thr_empty = 0; fifo_mode = 0; tick(); chk("R7", C_NONE);
    thr_empty = 1; tick(); chk("R7", C_TX);
    host_tx_wr = 1; thr_empty = 0; tick(); host_tx_wr = 0; chk("R7", C_NONE);
    thr_empty = 1; tick(); chk("R7", C_TX);
    host_isr_rd = 1; tick(); host_isr_rd = 0; chk("R7", C_NONE);
    tick(); chk("R7", C_NONE);
    rx_level = 1; tick(); chk("R8", C_RXL);
    rx_level = 0; tick(); chk("R8", C_NONE);
    rx_timeout = 1; tick(); rx_timeout = 0; chk("R8", C_NONE);
    tick(); chk("R8", C_NONE);
  endtask

  initial begin
    fifo_mode = 1; ier_rx_en = 1; ier_tx_en = 1;
    rx_level = 0; rx_trig = 4; tx_level = 0; tx_trig = 8;
    rx_timeout = 0; thr_empty = 0; host_tx_wr = 0; host_rx_rd = 0; host_isr_rd = 0;
    tick(); tick();
    rst_n = 1;
    tick();
    test_reset();
    test_rx_level();
    test_timeout();
    test_tx_fifo();
    test_priority();
    test_enables();
    test_nonfifo();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule